// File: doc/BRIEF.md
# Extended Integer Divide Unit

A sequential divider serving three divide instructions of a 16-bit microcontroller datapath. The instruction sequencer presents the accumulator D, the index registers X and Y, and an opcode select, then pulses a start strobe. The unit divides by X and hands back the updated register values with per-register write enables, the Z, N, V and C condition flags, and a one-cycle done strobe.

Two extended variants divide the 32-bit value formed by Y (upper half) and D (lower half). One treats it as unsigned and one as signed two's complement. In both, the quotient goes back to Y and the remainder to D. The short variant divides the signed value of D alone, returning the quotient in X and the remainder in D. Internally the operands are reduced to magnitudes and run through a restoring shift-subtract loop, one quotient bit per cycle. The signs are then applied to the results. Signed results truncate toward zero, and the remainder carries the sign of the dividend.

Top module: `ext_div_unit`

## Requirements
- R1: With `op_i` = 0, the unsigned 32-bit value {Y,D} is divided by unsigned X. The low 16 quotient bits appear on `y_o` with `y_we_o` set, and the remainder appears on `d_o` with `d_we_o` set.
- R2: With `op_i` = 1, the signed 32-bit {Y,D} is divided by signed X. Routing is the same as R1. The quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R3: With `op_i` = 2, signed D is divided by signed X. The quotient appears on `x_o` with `x_we_o` set, and the remainder appears on `d_o` with `d_we_o` set. `y_we_o` stays low.
- R4: When X is zero, C is 1, all write enables stay low and Z, N, V are 0. For any other divisor, C is 0 and exactly the two destination enables named in R1 to R3 are set.
- R5: Z is 1 exactly when the full quotient is zero. N equals bit 15 of the quotient.
- R6: For `op_i` = 0, V is 1 when any of quotient bits 31:16 is nonzero.
- R7: For `op_i` = 1 and `op_i` = 2, V is 1 when the signed quotient lies outside -32768..32767. For example, -32768 divided by -1 in the short variant sets V.
- R8: `done_o` is high for exactly one cycle, 2*W+1 clock cycles after the edge that accepts start (33 cycles for W=16). Write enables are high only while `done_o` is high.
- R9: A start while a division is in progress is ignored. The running division completes with its own operands, and no extra done follows.
- R10: A start with `op_i` = 3 is ignored, and no done follows it.
- R11: After reset, `done_o`, all write enables and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| op_i | input | 2 | 0 unsigned extended, 1 signed extended, 2 signed short, 3 ignored |
| d_i | input | 16 | Current D |
| x_i | input | 16 | Current X (divisor) |
| y_i | input | 16 | Current Y |
| d_o | output | 16 | New D (remainder) |
| x_o | output | 16 | New X (quotient, short variant) |
| y_o | output | 16 | New Y (quotient, extended variants) |
| d_we_o | output | 1 | Write D |
| x_we_o | output | 1 | Write X |
| y_we_o | output | 1 | Write Y |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, divide by zero |
| done_o | output | 1 | Result valid strobe |

## Verification
A miscounted step counter shows up on the very next division. Either done arrives on the wrong cycle, or the quotient is shifted by one or more bit positions, so every result is wrong. A wrongly latched sign or variant corrupts only part of the input space. Negative operands, divisions near the overflow boundary and the routing between X and Y are therefore driven directly, and random operands are mixed in around them. A busy flag that fails to hold shows up either as a second done or as a result computed from the operands of the intruding start.

// File: rtl/div_unit_pkg.sv
package div_unit_pkg;
  typedef enum logic [1:0] {
    OP_EXT_U   = 2'd0,
    OP_EXT_S   = 2'd1,
    OP_SHORT_S = 2'd2,
    OP_RSVD    = 2'd3
  } div_op_e;

  typedef enum logic {ST_IDLE, ST_RUN} div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_unit_pkg::*;
#(
  parameter int W = 16
) (
  input  div_op_e          op_i,
  input  logic [W-1:0]     d_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  output logic [2*W-1:0]   dvd_mag_o,
  output logic [W-1:0]     dvs_mag_o,
  output logic             dvd_neg_o,
  output logic             dvs_neg_o,
  output logic             dvs_zero_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] raw;
  logic          is_signed;

  always_comb begin
    raw        = (op_i == OP_SHORT_S) ? {{W{d_i[W-1]}}, d_i} : {y_i, d_i};
    is_signed  = (op_i != OP_EXT_U);
    dvd_neg_o  = is_signed & raw[DW-1];
    dvs_neg_o  = is_signed & x_i[W-1];
    dvd_mag_o  = dvd_neg_o ? -raw : raw;
    dvs_mag_o  = dvs_neg_o ? -x_i : x_i;
    dvs_zero_o = (x_i == '0);
  end
endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [2*W-1:0]   dvd_i,
  input  logic [W-1:0]     dvs_i,
  output logic [2*W-1:0]   quot_o,
  output logic [W-1:0]     rem_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] quot_q;
  logic [W-1:0]  rem_q, dvs_q;
  logic [W:0]    shifted, diff;
  logic          fit;

  // restoring step: partial remainder always stays below the divisor
  always_comb begin
    shifted = {rem_q, quot_q[DW-1]};
    diff    = shifted - {1'b0, dvs_q};
    fit     = (shifted >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else if (load_i) begin
      quot_q <= dvd_i;
      rem_q  <= '0;
      dvs_q  <= dvs_i;
    end else if (step_i) begin
      quot_q <= {quot_q[DW-2:0], fit};
      rem_q  <= fit ? diff[W-1:0] : shifted[W-1:0];
    end
  end

  assign quot_o = quot_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import div_unit_pkg::*;
#(
  parameter int W = 16
) (
  input  div_op_e          op_i,
  input  logic [2*W-1:0]   quot_mag_i,
  input  logic [W-1:0]     rem_mag_i,
  input  logic             dvd_neg_i,
  input  logic             dvs_neg_i,
  input  logic             dvs_zero_i,
  output logic [W-1:0]     quot_o,
  output logic [W-1:0]     rem_o,
  output logic             z_o,
  output logic             n_o,
  output logic             v_o,
  output logic             c_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] POS_LIM = DW'((64'd1 << (W - 1)) - 64'd1);
  localparam logic [DW-1:0] NEG_LIM = DW'(64'd1 << (W - 1));

  logic [DW-1:0] q_full;
  logic          q_neg;

  always_comb begin
    q_neg  = dvd_neg_i ^ dvs_neg_i;
    q_full = q_neg ? -quot_mag_i : quot_mag_i;
    quot_o = q_full[W-1:0];
    rem_o  = dvd_neg_i ? -rem_mag_i : rem_mag_i;
    c_o    = dvs_zero_i;
    if (dvs_zero_i) begin
      z_o = 1'b0;
      n_o = 1'b0;
      v_o = 1'b0;
    end else begin
      z_o = (quot_mag_i == '0);
      n_o = q_full[W-1];
      if (op_i == OP_EXT_U) v_o = |quot_mag_i[DW-1:W];
      else                  v_o = q_neg ? (quot_mag_i > NEG_LIM) : (quot_mag_i > POS_LIM);
    end
  end
endmodule

// File: rtl/ext_div_unit.sv
module ext_div_unit
  import div_unit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         d_we_o,
  output logic         x_we_o,
  output logic         y_we_o,
  output logic         flag_z_o,
  output logic         flag_n_o,
  output logic         flag_v_o,
  output logic         flag_c_o,
  output logic         done_o
);
  localparam int DW    = 2 * W;
  localparam int STEPS = DW;
  localparam int CNT_W = $clog2(STEPS + 1);

  div_state_e       state_q;
  div_op_e          op_in, op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dvd_neg_q, dvs_neg_q, zero_q;
  logic             accept, finish;

  logic [DW-1:0] dvd_mag, quot_mag;
  logic [W-1:0]  dvs_mag, rem_mag, quot_res, rem_res;
  logic          dvd_neg, dvs_neg, dvs_zero;
  logic          z_res, n_res, v_res, c_res;

  assign op_in  = div_op_e'(op_i);
  assign accept = start_i && (state_q == ST_IDLE) && (op_in != OP_RSVD);
  assign finish = (state_q == ST_RUN) && (cnt_q == CNT_W'(STEPS));

  div_operand_prep #(.W(W)) u_prep (
    .op_i      (op_in),
    .d_i       (d_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .dvd_neg_o (dvd_neg),
    .dvs_neg_o (dvs_neg),
    .dvs_zero_o(dvs_zero)
  );

  div_shift_core #(.W(W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .step_i((state_q == ST_RUN) && !finish),
    .dvd_i (dvd_mag),
    .dvs_i (dvs_mag),
    .quot_o(quot_mag),
    .rem_o (rem_mag)
  );

  div_result_fix #(.W(W)) u_fix (
    .op_i      (op_q),
    .quot_mag_i(quot_mag),
    .rem_mag_i (rem_mag),
    .dvd_neg_i (dvd_neg_q),
    .dvs_neg_i (dvs_neg_q),
    .dvs_zero_i(zero_q),
    .quot_o    (quot_res),
    .rem_o     (rem_res),
    .z_o       (z_res),
    .n_o       (n_res),
    .v_o       (v_res),
    .c_o       (c_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_EXT_U;
      cnt_q     <= '0;
      dvd_neg_q <= 1'b0;
      dvs_neg_q <= 1'b0;
      zero_q    <= 1'b0;
    end else if (accept) begin
      state_q   <= ST_RUN;
      op_q      <= op_in;
      cnt_q     <= '0;
      dvd_neg_q <= dvd_neg;
      dvs_neg_q <= dvs_neg;
      zero_q    <= dvs_zero;
    end else if (finish) begin
      state_q   <= ST_IDLE;
    end else if (state_q == ST_RUN) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o      <= '0;
      x_o      <= '0;
      y_o      <= '0;
      d_we_o   <= 1'b0;
      x_we_o   <= 1'b0;
      y_we_o   <= 1'b0;
      flag_z_o <= 1'b0;
      flag_n_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_c_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (finish) begin
      d_o      <= rem_res;
      x_o      <= quot_res;
      y_o      <= quot_res;
      d_we_o   <= !zero_q;
      x_we_o   <= !zero_q && (op_q == OP_SHORT_S);
      y_we_o   <= !zero_q && (op_q != OP_SHORT_S);
      flag_z_o <= z_res;
      flag_n_o <= n_res;
      flag_v_o <= v_res;
      flag_c_o <= c_res;
      done_o   <= 1'b1;
    end else begin
      d_we_o   <= 1'b0;
      x_we_o   <= 1'b0;
      y_we_o   <= 1'b0;
      done_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/div_unit_checker.sv
module div_unit_checker #(
  parameter int W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] op_i,
  input logic       d_we_o,
  input logic       x_we_o,
  input logic       y_we_o,
  input logic       flag_z_o,
  input logic       flag_n_o,
  input logic       flag_v_o,
  input logic       flag_c_o,
  input logic       done_o
);
  localparam int LAT   = 2 * W + 1;
  localparam int CNT_W = $clog2(LAT + 2);

  logic             ck_busy;
  logic [CNT_W-1:0] ck_cnt;

  // independent model of acceptance and elapsed cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_busy <= 1'b0;
      ck_cnt  <= '0;
    end else if (start_i && (op_i != 2'd3) && (!ck_busy || done_o)) begin
      ck_busy <= 1'b1;
      ck_cnt  <= '0;
    end else if (done_o) begin
      ck_busy <= 1'b0;
    end else if (ck_busy && ck_cnt != '1) begin
      ck_cnt  <= ck_cnt + 1'b1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_we_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o || x_we_o || y_we_o) |-> done_o);

  p_done_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ck_busy && ck_cnt == CNT_W'(LAT)));

  p_done_due_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_busy && ck_cnt == CNT_W'(LAT)) |-> done_o);

  p_zero_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_c_o) |-> !(d_we_o || x_we_o || y_we_o || flag_z_o || flag_n_o || flag_v_o));

  p_dest_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !flag_c_o) |-> (d_we_o && (x_we_o ^ y_we_o)));
endmodule

bind ext_div_unit div_unit_checker #(.W(W)) u_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .d_we_o  (d_we_o),
  .x_we_o  (x_we_o),
  .y_we_o  (y_we_o),
  .flag_z_o(flag_z_o),
  .flag_n_o(flag_n_o),
  .flag_v_o(flag_v_o),
  .flag_c_o(flag_c_o),
  .done_o  (done_o)
);

// File: tb/ext_div_unit_test.sv
module ext_div_unit_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  W          = 16;
  localparam int  LAT_NEG    = 2 * W + 2; // falling edges from drive to visible done

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   op_i = 2'd0;
  logic [W-1:0] d_i = '0, x_i = '0, y_i = '0;
  logic [W-1:0] d_o, x_o, y_o;
  logic         d_we_o, x_we_o, y_we_o;
  logic         flag_z_o, flag_n_o, flag_v_o, flag_c_o, done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ext_div_unit #(.W(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .d_i(d_i), .x_i(x_i), .y_i(y_i),
    .d_o(d_o), .x_o(x_o), .y_o(y_o),
    .d_we_o(d_we_o), .x_we_o(x_we_o), .y_we_o(y_we_o),
    .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model straight from the requirements
  task automatic ref_div(input logic [1:0] op, input logic [15:0] d, x, y,
                         output logic [15:0] eq, er,
                         output logic ez, en, ev, ec);
    longint a, b, q, r;
    if (op == 2'd0)      begin a = longint'({y, d}); b = longint'(x); end
    else if (op == 2'd1) begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
    else                 begin a = longint'($signed(d)); b = longint'($signed(x)); end
    eq = '0; er = '0; ez = 0; en = 0; ev = 0; ec = 0;
    if (b == 0) begin
      ec = 1;
    end else begin
      q  = a / b;
      r  = a % b;
      eq = q[15:0];
      er = r[15:0];
      ez = (q == 0);
      en = q[15];
      if (op == 2'd0) ev = (q[31:16] != 0);
      else            ev = (q > 32767) || (q < -32768);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] d, x, y, input bool_busy_poke);
    logic [15:0] eq, er;
    logic ez, en, ev, ec;
    int n;
    bit seen;
    string tag;
    ref_div(op, d, x, y, eq, er, ez, en, ev, ec);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; d_i = d; x_i = x; y_i = y;
    n = 0; seen = 0;
    while (n < LAT_NEG + 20) begin
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
      if (bool_busy_poke && n == 5) begin
        // R9: intruding start with different operands
        start_i = 1'b1; op_i = 2'd0; d_i = 16'h1234; x_i = 16'h0003; y_i = 16'h0000;
      end
      if (done_o) begin seen = 1; break; end
    end
    check(seen, "R8 done seen", longint'(seen), 1);
    if (!seen) return;
    check(n == LAT_NEG, "R8 latency", n, LAT_NEG);
    tag = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : "R3";
    check(flag_c_o == ec, "R4 carry", flag_c_o, ec);
    if (ec) begin
      check({d_we_o, x_we_o, y_we_o} == 3'b000, "R4 no write", {d_we_o, x_we_o, y_we_o}, 0);
      check({flag_z_o, flag_n_o, flag_v_o} == 3'b000, "R4 znv", {flag_z_o, flag_n_o, flag_v_o}, 0);
    end else begin
      check(d_o == er, {tag, " remainder"}, d_o, er);
      if (op == 2'd2) begin
        check(x_o == eq, "R3 quotient", x_o, eq);
        check({d_we_o, x_we_o, y_we_o} == 3'b110, "R3 enables", {d_we_o, x_we_o, y_we_o}, 3'b110);
      end else begin
        check(y_o == eq, {tag, " quotient"}, y_o, eq);
        check({d_we_o, x_we_o, y_we_o} == 3'b101, {tag, " enables"}, {d_we_o, x_we_o, y_we_o}, 3'b101);
      end
      check(flag_z_o == ez, "R5 zero", flag_z_o, ez);
      check(flag_n_o == en, "R5 negative", flag_n_o, en);
      check(flag_v_o == ev, (op == 2'd0) ? "R6 overflow" : "R7 overflow", flag_v_o, ev);
    end
    @(negedge clk_i);
    check(!done_o && !d_we_o && !x_we_o && !y_we_o, "R8 single pulse", done_o, 0);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    bit any = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) any = 1;
    end
    check(!any, req, any, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check({done_o, d_we_o, x_we_o, y_we_o} == 4'b0, "R11 outputs", {done_o, d_we_o, x_we_o, y_we_o}, 0);
    check({flag_z_o, flag_n_o, flag_v_o, flag_c_o} == 4'b0, "R11 flags",
          {flag_z_o, flag_n_o, flag_v_o, flag_c_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    run_op(2'd0, 16'h0064, 16'h0007, 16'h0000, 0); // R1 plain
    run_op(2'd0, 16'h0000, 16'h0001, 16'h0001, 0); // R6 quotient 0x10000
    run_op(2'd0, 16'hFFFF, 16'hFFFF, 16'hFFFE, 0); // R6 largest no-overflow
    run_op(2'd0, 16'h0005, 16'h0009, 16'h0000, 0); // R5 zero quotient
    run_op(2'd1, 16'hFFF9, 16'h0002, 16'hFFFF, 0); // R2 -7/2
    run_op(2'd1, 16'h0007, 16'hFFFE, 16'h0000, 0); // R2 7/-2
    run_op(2'd1, 16'h0000, 16'hFFFF, 16'h8000, 0); // R7 min/-1
    run_op(2'd1, 16'h0000, 16'h0001, 16'hFFFF, 0); // R7 -65536/1
    run_op(2'd2, 16'h8000, 16'hFFFF, 16'h0000, 0); // R7 short -32768/-1
    run_op(2'd2, 16'hFF9C, 16'h0007, 16'hABCD, 0); // R3 -100/7
    run_op(2'd2, 16'h8000, 16'h0001, 16'h0000, 0); // R5 negative bound
    run_op(2'd0, 16'h1234, 16'h0000, 16'h5678, 0); // R4
    run_op(2'd1, 16'h1234, 16'h0000, 16'h8000, 0); // R4
    run_op(2'd2, 16'h8000, 16'h0000, 16'h0000, 0); // R4
    run_op(2'd1, 16'h4321, 16'h0013, 16'hF000, 1); // R9 busy start ignored
    expect_quiet("R9 no extra done", 45);

    // R10 reserved op
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd3; d_i = 16'd10; x_i = 16'd2; y_i = 16'd0;
    expect_quiet("R10 reserved ignored", 45);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  op;
      logic [15:0] d, x, y;
      op = 2'($urandom_range(0, 2));
      d  = 16'($urandom);
      y  = 16'($urandom);
      case ($urandom_range(0, 5))
        0:       x = 16'd0;
        1:       x = 16'($urandom_range(1, 15));
        2:       x = -16'($urandom_range(1, 15));
        default: x = 16'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) y = {16{d[15]}};
      run_op(op, d, x, y, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule